// File: doc/BRIEF.md
# Nibble-Serial Host Bus Transaction Monitor

This block watches a four-bit, nibble-serial host bus and its active-low frame strobe without ever driving them. On every rising clock edge it samples the strobe and the nibble lines and follows each transfer through its fields in order. Those fields are the start code, the cycle-type nibble, the address, the first two-clock turn-around, the handshake (sync) phase, one data byte and the closing two-clock turn-around. Input/output and memory cycles, reads and writes, with one data byte each, are covered.

Each decoded field leaves the block as one event carrying a kind code and a value. Four separate one-clock warning flags mark protocol violations:

- nibble lines that change while the strobe is held low,
- reserved cycle-type codes,
- reserved sync codes,
- turn-around nibbles other than all ones.

The event stream has a valid strobe and no ready input. A passive monitor cannot stall the bus it observes, so every event must be taken in the clock it is offered. `ev_value` is meaningful only while `ev_valid` is high.

Top module: `hbus_txn_monitor`

## Requirements
- R1: A synchronous active-high `rst` returns the monitor to idle, and no event or warning is produced after reset until the strobe is next sampled low, even if reset arrives mid-transfer.
- R2: A transfer begins when `bus_frame_n` is sampled low. While it stays low the monitor stays in the start phase. On the first clock it is sampled high again, one start event (kind 0) is issued whose value is the nibble sampled on the last low clock.
- R3: When `bus_nib` differs from the previous clock's value while `bus_frame_n` is low on both clocks, `warn_unstable` pulses with no event in that clock.
- R4: The nibble sampled on the first high clock is the cycle type. It is reported as a kind 1 event, with the raw nibble as value, in the clock after the start event. Bits [3:1] equal to 000 (I/O read), 001 (I/O write), 010 (memory read) or 011 (memory write) are valid. Any other value (bit 3 set) pulses `warn_ctype` together with the start event and returns the monitor to idle.
- R5: I/O cycles take 4 address nibbles and memory cycles take 8, most significant first. A kind 2 event carries the zero-extended address in the clock after the last address nibble.
- R6: Each turn-around lasts two clocks and gives one event per clock: kind 3 for the first turn-around, kind 6 for the second. The value is {clock index, nibble}, with index 0 then 1. `warn_tar` pulses alongside whenever the nibble is not 1111.
- R7: Every sync clock gives a kind 4 event with the nibble as value. 0000 moves on to data; 0101 and 0110 are wait states that stay in sync; 1010 is an error that ends the transfer without a warning; any other code pulses `warn_sync` and ends the transfer.
- R8: The data byte is taken low nibble first over two clocks, and a kind 5 event with the byte is issued after the second; the second turn-around follows.
- R9: `bus_frame_n` sampled low in any phase abandons the current transfer and restarts start handling with that clock's nibble.
- R10: Events and warnings are registered one-clock pulses appearing after the clock edge that sampled the field's final nibble (the cycle-type event one clock later), with at most one event per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_frame_n | input | 1 | Observed active-low frame strobe |
| bus_nib | input | 4 | Observed nibble lines |
| ev_valid | output | 1 | One-clock event strobe, no back-pressure |
| ev_kind | output | 3 | Event kind: 0 start, 1 cycle type, 2 address, 3 first turn-around, 4 sync, 5 data, 6 second turn-around |
| ev_value | output | 32 | Field value, zero-extended |
| warn_unstable | output | 1 | Nibble changed while strobe held low |
| warn_ctype | output | 1 | Reserved cycle-type code |
| warn_tar | output | 1 | Turn-around nibble not 1111 |
| warn_sync | output | 1 | Reserved sync code |

## Verification
A phase register that is off by one state shows within a clock or two: an event with the wrong kind, or an event where the bench expects silence. A wrong address-length choice shows as an address event four clocks early or late, and the error then carries into every later field of that transfer. A start or data latch holding a stale nibble shows only in the value of the next start or data event. For that reason every transfer in the bench varies its start nibble, its address digits and its data byte. Missed aborts and missed reset recovery show as stray address events from a stale address phase during idle clocks, which the scoreboard reports as unexpected output.

// File: rtl/hbus_mon_pkg.sv
`timescale 1ns/1ps
package hbus_mon_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_ADDR, PH_TAR1, PH_SYNC, PH_DATA, PH_TAR2
  } phase_e;

  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_CTYPE = 3'd1,
    EV_ADDR  = 3'd2,
    EV_TAR1  = 3'd3,
    EV_SYNC  = 3'd4,
    EV_DATA  = 3'd5,
    EV_TAR2  = 3'd6
  } ev_kind_e;

  localparam logic [NIB_W-1:0] SYNC_READY  = 4'h0;
  localparam logic [NIB_W-1:0] SYNC_WAIT_S = 4'h5;
  localparam logic [NIB_W-1:0] SYNC_WAIT_L = 4'h6;
  localparam logic [NIB_W-1:0] SYNC_ERROR  = 4'hA;
  localparam logic [NIB_W-1:0] TAR_PULLED  = 4'hF;

  // cycle type lives on bits [3:1]; only 000..011 are decoded
  function automatic logic ctype_reserved(input logic [NIB_W-1:0] n);
    return n[3];
  endfunction

  function automatic logic ctype_is_mem(input logic [NIB_W-1:0] n);
    return n[2];
  endfunction

  function automatic logic sync_is_wait(input logic [NIB_W-1:0] n);
    return (n == SYNC_WAIT_S) || (n == SYNC_WAIT_L);
  endfunction

  function automatic logic sync_reserved(input logic [NIB_W-1:0] n);
    return !((n == SYNC_READY) || sync_is_wait(n) || (n == SYNC_ERROR));
  endfunction

endpackage

// File: rtl/hbus_phase_ctrl.sv
`timescale 1ns/1ps
module hbus_phase_ctrl
  import hbus_mon_pkg::*;
#(
  parameter int IO_NIBS  = 4,
  parameter int MEM_NIBS = 8,
  parameter int CNT_W    = $clog2(MEM_NIBS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  output phase_e           phase_o,
  output logic             cnt_lsb_o,
  output logic             pend_o,
  output logic             ev_valid_o,
  output logic [2:0]       ev_kind_o
);

  localparam logic [CNT_W-1:0] IO_LAST  = CNT_W'(IO_NIBS - 1);
  localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(MEM_NIBS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mem_q, mem_d;
  logic             pend_q, pend_d;
  logic             emit;
  ev_kind_e         kind;
  logic [CNT_W-1:0] addr_last;

  assign addr_last = mem_q ? MEM_LAST : IO_LAST;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    mem_d   = mem_q;
    pend_d  = 1'b0;
    emit    = pend_q;          // delayed cycle-type report
    kind    = EV_CTYPE;
    if (!frame_n) begin
      phase_d = PH_START;      // fresh start or abort
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_d = PH_IDLE;
        end
        PH_START: begin
          emit    = 1'b1;
          kind    = EV_START;
          pend_d  = 1'b1;
          mem_d   = ctype_is_mem(nib);
          cnt_d   = '0;
          phase_d = ctype_reserved(nib) ? PH_IDLE : PH_ADDR;
        end
        PH_ADDR: begin
          if (cnt_q == addr_last) begin
            emit    = 1'b1;
            kind    = EV_ADDR;
            cnt_d   = '0;
            phase_d = PH_TAR1;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        PH_TAR1: begin
          emit = 1'b1;
          kind = EV_TAR1;
          if (cnt_q[0]) begin
            cnt_d   = '0;
            phase_d = PH_SYNC;
          end else begin
            cnt_d = CNT_ONE;
          end
        end
        PH_SYNC: begin
          emit = 1'b1;
          kind = EV_SYNC;
          if (nib == SYNC_READY) begin
            cnt_d   = '0;
            phase_d = PH_DATA;
          end else if (!sync_is_wait(nib)) begin
            phase_d = PH_IDLE;
          end
        end
        PH_DATA: begin
          if (cnt_q[0]) begin
            emit    = 1'b1;
            kind    = EV_DATA;
            cnt_d   = '0;
            phase_d = PH_TAR2;
          end else begin
            cnt_d = CNT_ONE;
          end
        end
        PH_TAR2: begin
          emit = 1'b1;
          kind = EV_TAR2;
          if (cnt_q[0]) begin
            cnt_d   = '0;
            phase_d = PH_IDLE;
          end else begin
            cnt_d = CNT_ONE;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      mem_q      <= 1'b0;
      pend_q     <= 1'b0;
      ev_valid_o <= 1'b0;
      ev_kind_o  <= '0;
    end else begin
      phase_q    <= phase_d;
      cnt_q      <= cnt_d;
      mem_q      <= mem_d;
      pend_q     <= pend_d;
      ev_valid_o <= emit;
      ev_kind_o  <= kind;
    end
  end

  assign phase_o   = phase_q;
  assign cnt_lsb_o = cnt_q[0];
  assign pend_o    = pend_q;

  AST_FRAME_LOW_ENTERS_START: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> phase_q == PH_START); // R9

  AST_ADDR_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_ADDR |-> cnt_q <= addr_last); // R5

endmodule

// File: rtl/hbus_field_accum.sv
`timescale 1ns/1ps
module hbus_field_accum
  import hbus_mon_pkg::*;
#(
  parameter int VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  input  phase_e           phase,
  input  logic             cnt_lsb,
  input  logic             pend,
  output logic [NIB_W-1:0] start_nib_o,
  output logic [VAL_W-1:0] ev_value_o
);

  logic [NIB_W-1:0] start_q;
  logic [NIB_W-1:0] ctype_q;
  logic [NIB_W-1:0] data_lo_q;
  logic [VAL_W-1:0] addr_q;
  logic [VAL_W-1:0] addr_shift;
  logic [VAL_W-1:0] val_d;

  assign addr_shift = {addr_q[VAL_W-NIB_W-1:0], nib};

  always_comb begin
    val_d = '0;
    if (pend) begin
      val_d = VAL_W'(ctype_q);
    end else if (frame_n) begin
      case (phase)
        PH_START: val_d = VAL_W'(start_q);
        PH_ADDR:  val_d = addr_shift;
        PH_TAR1,
        PH_TAR2:  val_d = VAL_W'({cnt_lsb, nib});
        PH_SYNC:  val_d = VAL_W'(nib);
        PH_DATA:  val_d = VAL_W'({nib, data_lo_q});
        default:  val_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q    <= '0;
      ctype_q    <= '0;
      data_lo_q  <= '0;
      addr_q     <= '0;
      ev_value_o <= '0;
    end else begin
      ev_value_o <= val_d;
      if (!frame_n) begin
        start_q <= nib;
      end else begin
        if (phase == PH_START) begin
          ctype_q <= nib;
          addr_q  <= '0;
        end
        if (phase == PH_ADDR) addr_q <= addr_shift;
        if (phase == PH_DATA && !cnt_lsb) data_lo_q <= nib;
      end
    end
  end

  assign start_nib_o = start_q;

endmodule

// File: rtl/hbus_rule_check.sv
`timescale 1ns/1ps
module hbus_rule_check
  import hbus_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  input  phase_e           phase,
  input  logic [NIB_W-1:0] start_nib,
  output logic             warn_unstable_o,
  output logic             warn_ctype_o,
  output logic             warn_tar_o,
  output logic             warn_sync_o
);

  logic in_tar;
  assign in_tar = (phase == PH_TAR1) || (phase == PH_TAR2);

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_unstable_o <= 1'b0;
      warn_ctype_o    <= 1'b0;
      warn_tar_o      <= 1'b0;
      warn_sync_o     <= 1'b0;
    end else begin
      warn_unstable_o <= !frame_n && (phase == PH_START) && (nib != start_nib);
      warn_ctype_o    <= frame_n && (phase == PH_START) && ctype_reserved(nib);
      warn_tar_o      <= frame_n && in_tar && (nib != TAR_PULLED);
      warn_sync_o     <= frame_n && (phase == PH_SYNC) && sync_reserved(nib);
    end
  end

  AST_UNSTABLE_NEEDS_LOW_FRAME: assert property (@(posedge clk) disable iff (rst)
    warn_unstable_o |-> $past(!frame_n)); // R3

endmodule

// File: rtl/hbus_txn_monitor.sv
`timescale 1ns/1ps
module hbus_txn_monitor
  import hbus_mon_pkg::*;
#(
  parameter int IO_ADDR_NIBS  = 4,
  parameter int MEM_ADDR_NIBS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_frame_n,
  input  logic [3:0]                   bus_nib,
  output logic                         ev_valid,
  output logic [2:0]                   ev_kind,
  output logic [MEM_ADDR_NIBS*4-1:0]   ev_value,
  output logic                         warn_unstable,
  output logic                         warn_ctype,
  output logic                         warn_tar,
  output logic                         warn_sync
);

  localparam int VAL_W = MEM_ADDR_NIBS * NIB_W;
  localparam int CNT_W = $clog2(MEM_ADDR_NIBS);

  phase_e           phase;
  logic             cnt_lsb;
  logic             pend;
  logic [NIB_W-1:0] start_nib;

  hbus_phase_ctrl #(
    .IO_NIBS  (IO_ADDR_NIBS),
    .MEM_NIBS (MEM_ADDR_NIBS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (bus_frame_n),
    .nib        (bus_nib),
    .phase_o    (phase),
    .cnt_lsb_o  (cnt_lsb),
    .pend_o     (pend),
    .ev_valid_o (ev_valid),
    .ev_kind_o  (ev_kind)
  );

  hbus_field_accum #(
    .VAL_W (VAL_W)
  ) u_accum (
    .clk         (clk),
    .rst         (rst),
    .frame_n     (bus_frame_n),
    .nib         (bus_nib),
    .phase       (phase),
    .cnt_lsb     (cnt_lsb),
    .pend        (pend),
    .start_nib_o (start_nib),
    .ev_value_o  (ev_value)
  );

  hbus_rule_check u_rules (
    .clk             (clk),
    .rst             (rst),
    .frame_n         (bus_frame_n),
    .nib             (bus_nib),
    .phase           (phase),
    .start_nib       (start_nib),
    .warn_unstable_o (warn_unstable),
    .warn_ctype_o    (warn_ctype),
    .warn_tar_o      (warn_tar),
    .warn_sync_o     (warn_sync)
  );

  AST_CTYPE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == EV_CTYPE) |-> $past(ev_valid && ev_kind == EV_START)); // R4

  AST_CTYPE_WARN_WITH_START: assert property (@(posedge clk) disable iff (rst)
    warn_ctype |-> (ev_valid && ev_kind == EV_START)); // R4

  AST_TAR_WARN_WITH_TAR: assert property (@(posedge clk) disable iff (rst)
    warn_tar |-> (ev_valid && (ev_kind == EV_TAR1 || ev_kind == EV_TAR2))); // R6

  AST_SYNC_WARN_WITH_SYNC: assert property (@(posedge clk) disable iff (rst)
    warn_sync |-> (ev_valid && ev_kind == EV_SYNC)); // R7

  AST_UNSTABLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    warn_unstable |-> !ev_valid); // R3

  AST_DATA_THEN_TAR2: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == EV_DATA) |-> phase == PH_TAR2); // R8

endmodule

// File: tb/hbus_txn_monitor_bench.sv
`timescale 1ns/1ps
module hbus_txn_monitor_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_n;
  logic [3:0]  nib;
  logic        ev_valid;
  logic [2:0]  ev_kind;
  logic [31:0] ev_value;
  logic        warn_unstable, warn_ctype, warn_tar, warn_sync;

  int checks = 0;
  int errors = 0;
  bit running = 1'b1;

  always #2.5 clk = ~clk;

  hbus_txn_monitor u_hbus_txn_monitor (
    .clk           (clk),
    .rst           (rst),
    .bus_frame_n   (frame_n),
    .bus_nib       (nib),
    .ev_valid      (ev_valid),
    .ev_kind       (ev_kind),
    .ev_value      (ev_value),
    .warn_unstable (warn_unstable),
    .warn_ctype    (warn_ctype),
    .warn_tar      (warn_tar),
    .warn_sync     (warn_sync)
  );

  // warn order: {unstable, ctype, tar, sync}
  typedef struct packed {
    logic        e;
    logic [2:0]  k;
    logic [31:0] v;
    logic [3:0]  w;
  } item_t;

  item_t expq[$];

  function automatic string req_of(item_t it);
    if (it.w[3]) return "R3";
    if (it.w[2]) return "R4";
    if (it.w[1]) return "R6";
    if (it.w[0]) return "R7";
    case (it.k)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd6: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic push(input logic e, input logic [2:0] k, input logic [31:0] v, input logic [3:0] w);
    item_t it;
    it.e = e; it.k = k; it.v = v; it.w = w;
    expq.push_back(it);
  endtask

  task automatic step(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    nib     = n;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    item_t x;
    logic [3:0] wv;
    #1;
    wv = {warn_unstable, warn_ctype, warn_tar, warn_sync};
    if (!rst && (ev_valid || (wv != 4'b0))) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected output: actual valid=%0b kind=%0d value=%h warn=%b, expected none",
                 ev_valid, ev_kind, ev_value, wv);
      end else begin
        x = expq.pop_front();
        if (ev_valid !== x.e || wv !== x.w ||
            (x.e && (ev_kind !== x.k || ev_value !== x.v))) begin
          errors++;
          $display("FAIL %s: actual valid=%0b kind=%0d value=%h warn=%b, expected valid=%0b kind=%0d value=%h warn=%b",
                   req_of(x), ev_valid, ev_kind, ev_value, wv, x.e, x.k, x.v, x.w);
        end
      end
    end
  end

  task automatic tx_start(input logic [3:0] n);
    step(1'b0, n);
  endtask

  task automatic tx_ctype(input logic [3:0] start_val, input logic [3:0] ct);
    push(1'b1, 3'd0, 32'(start_val), {1'b0, ct[3], 2'b00});
    step(1'b1, ct);
  endtask

  task automatic tx_addr(input logic [3:0] ct, input logic [31:0] addr, input int nibs);
    for (int i = 0; i < nibs; i++) begin
      if (i == 0) push(1'b1, 3'd1, 32'(ct), 4'b0000);
      if (i == nibs - 1) push(1'b1, 3'd2, addr, 4'b0000);
      step(1'b1, addr[4*(nibs-1-i) +: 4]);
    end
  endtask

  task automatic tx_tar(input logic [2:0] k, input logic [3:0] n0, input logic [3:0] n1);
    push(1'b1, k, 32'({1'b0, n0}), {2'b00, n0 != 4'hF, 1'b0});
    step(1'b1, n0);
    push(1'b1, k, 32'({1'b1, n1}), {2'b00, n1 != 4'hF, 1'b0});
    step(1'b1, n1);
  endtask

  task automatic tx_sync(input logic [3:0] n);
    logic rsv;
    rsv = !(n == 4'h0 || n == 4'h5 || n == 4'h6 || n == 4'hA);
    push(1'b1, 3'd4, 32'(n), {3'b000, rsv});
    step(1'b1, n);
  endtask

  task automatic tx_data(input logic [7:0] b);
    step(1'b1, b[3:0]);
    push(1'b1, 3'd5, 32'(b), 4'b0000);
    step(1'b1, b[7:4]);
  endtask

  task automatic drain(input string req);
    repeat (6) step(1'b1, 4'h9);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d expected events still pending, expected 0", req, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    rst = 1'b1; frame_n = 1'b1; nib = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (ev_valid || warn_unstable || warn_ctype || warn_tar || warn_sync) begin
      errors++;
      $display("FAIL R1: actual valid=%0b warns=%b, expected all zero after reset",
               ev_valid, {warn_unstable, warn_ctype, warn_tar, warn_sync});
    end

    // R2 R5 R6 R7 R8: I/O read, one wait state
    tx_start(4'h0);
    tx_ctype(4'h0, 4'h0);
    tx_addr(4'h0, 32'h0000_1234, 4);
    tx_tar(3'd3, 4'hF, 4'hF);
    tx_sync(4'h5);
    tx_sync(4'h0);
    tx_data(8'hC3);
    tx_tar(3'd6, 4'hF, 4'hF);
    drain("R8");

    // R2 R3: held strobe with changing nibble, last low value used; memory write; bad TAR; error sync
    tx_start(4'h3);
    push(1'b0, 3'd0, 32'h0, 4'b1000);
    tx_start(4'h2);
    tx_ctype(4'h2, 4'h6);
    tx_addr(4'h6, 32'hFEDC_BA98, 8);
    tx_tar(3'd3, 4'h7, 4'hF);
    tx_sync(4'h6);
    tx_sync(4'hA);
    drain("R7");

    // R4: reserved cycle type, reported then idle
    tx_start(4'h1);
    tx_ctype(4'h1, 4'h8);
    push(1'b1, 3'd1, 32'h8, 4'b0000);
    step(1'b1, 4'h4);
    drain("R4");

    // R7: reserved sync ends the transfer; I/O write
    tx_start(4'h0);
    tx_ctype(4'h0, 4'h2);
    tx_addr(4'h2, 32'h0000_ABCD, 4);
    tx_tar(3'd3, 4'hF, 4'hF);
    tx_sync(4'h3);
    drain("R7");

    // R9: abort inside the address phase, then a full memory read with bad second TAR
    tx_start(4'h0);
    tx_ctype(4'h0, 4'h0);
    push(1'b1, 3'd1, 32'h0, 4'b0000);
    step(1'b1, 4'h1);
    step(1'b1, 4'h2);
    tx_start(4'h5);
    tx_ctype(4'h5, 4'h4);
    tx_addr(4'h4, 32'h1357_9BDF, 8);
    tx_tar(3'd3, 4'hF, 4'hF);
    tx_sync(4'h0);
    tx_data(8'h5A);
    tx_tar(3'd6, 4'hF, 4'h0);
    drain("R9");

    // R1: reset mid-transfer leaves the monitor idle
    tx_start(4'h0);
    tx_ctype(4'h0, 4'h0);
    @(negedge clk); rst = 1'b1; frame_n = 1'b1;
    @(negedge clk); rst = 1'b0;
    expq.delete();
    drain("R1");

    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (running) begin
      errors++;
      $display("FAIL R10 watchdog: actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule